// File: doc/BRIEF.md
# Exception Return Frame Restore Sequencer

This block performs the context-restore half of a return-from-exception. On a start strobe it takes the current supervisor stack pointer from the core and reads the frame at the top of the stack through a simple word-read port. The first word it reads is the format word. That word decides whether the frame is a short frame, a long frame or a bus-fault frame, or whether it is rejected. It then reads the saved status word and both halves of the saved program counter. Finally it updates the status register, program counter and stack pointer in one cycle.

A bus-fault frame must pass two checks before anything is restored. Its format code must be valid, and a version nibble stored in the frame must equal the block's fixed `VERSION` parameter. A frame with an unknown code fails. So does a fault frame whose version does not match. In either case the block raises a format-error flag together with its done pulse, and it leaves all three context registers untouched.

Top module: `rte_restore_seq`

## Requirements
- R1: After reset, `sr_o`, `pc_o` and `ssp_o` are zero, `done_o` and `fmt_err_o` are low and no read is requested.
- R2: A start strobe latches `ssp_i` as the frame base. The first read is at base+6, the format word, whose bits [15:12] hold the format code.
- R3: Code 0 (short frame): the block reads SR at base+0, then PC high at base+2, then PC low at base+4. It sets `sr_o` to the SR word, `pc_o` to {PC high, PC low} and `ssp_o` to base+8. The operation makes exactly 4 reads.
- R4: Code 2 (long frame): the reads and restore are the same as R3, but `ssp_o` becomes base+12.
- R5: Code 0xC (fault frame): the second read is at base+8. Bits [15:12] of that word must equal `VERSION`. When they do, the block restores as in R3 with `ssp_o` set to base+24, using 5 reads in total.
- R6: Any other code ends the operation after the format read, which is 1 read. `fmt_err_o` and `done_o` pulse, and `sr_o`, `pc_o` and `ssp_o` keep their old values.
- R7: A fault frame with a wrong version ends after 2 reads with `fmt_err_o` and `done_o`, and the context outputs are unchanged.
- R8: `sr_o`, `pc_o` and `ssp_o` change only in the cycle where `done_o` is high and `fmt_err_o` is low, and all three are written together.
- R9: `done_o` is a one-cycle pulse, issued once per operation, after which the block accepts a new start.
- R10: While `rd_req_o` is high and `rd_valid_i` is low, `rd_addr_o` holds steady.
- R11: A start strobe that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a restore (one-cycle strobe) |
| ssp_i | input | AW | Current supervisor stack pointer (frame base) |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | AW | Byte address of the requested word |
| rd_data_i | input | DW | Read data, valid with `rd_valid_i` |
| rd_valid_i | input | 1 | Read completes this cycle |
| sr_o | output | DW | Restored status register |
| pc_o | output | 2*DW | Restored program counter |
| ssp_o | output | AW | Updated stack pointer |
| done_o | output | 1 | Operation finished (one cycle) |
| fmt_err_o | output | 1 | Frame rejected, high with `done_o` |

## Verification
The bench builds the block with `AW`=10 and `VERSION`=0xA. With these values a 512-word memory covers the whole address space, so frames placed near the top of memory exercise pointer wrap-around. The bench sweeps all sixteen format codes, with both a matching and a mismatching version nibble for the fault code, at read latencies of 0 to 2 wait cycles. For every case it checks the read count, the first address, the outputs and the carried-over context.

// File: rtl/rte_pkg.sv
package rte_pkg;

  localparam logic [3:0] FMT_SHORT = 4'h0;
  localparam logic [3:0] FMT_LONG  = 4'h2;
  localparam logic [3:0] FMT_FAULT = 4'hC;

  localparam logic [3:0] OFS_SR  = 4'd0;
  localparam logic [3:0] OFS_PCH = 4'd2;
  localparam logic [3:0] OFS_PCL = 4'd4;
  localparam logic [3:0] OFS_FMT = 4'd6;
  localparam logic [3:0] OFS_VER = 4'd8;

  typedef enum logic [1:0] {
    FR_SHORT = 2'd0,
    FR_LONG  = 2'd1,
    FR_FAULT = 2'd2,
    FR_BAD   = 2'd3
  } frame_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FMT  = 3'd1,
    ST_VER  = 3'd2,
    ST_SR   = 3'd3,
    ST_PCH  = 3'd4,
    ST_PCL  = 3'd5
  } seq_state_e;

  function automatic logic [4:0] frame_bytes(frame_kind_e k);
    case (k)
      FR_SHORT: frame_bytes = 5'd8;
      FR_LONG:  frame_bytes = 5'd12;
      FR_FAULT: frame_bytes = 5'd24;
      default:  frame_bytes = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/rte_frame_decode.sv
module rte_frame_decode
  import rte_pkg::*;
(
  input  logic [3:0]  code_i,
  output frame_kind_e kind_o
);

  always_comb begin
    case (code_i)
      FMT_SHORT: kind_o = FR_SHORT;
      FMT_LONG:  kind_o = FR_LONG;
      FMT_FAULT: kind_o = FR_FAULT;
      default:   kind_o = FR_BAD;
    endcase
  end

endmodule

// File: rtl/rte_addr_gen.sv
module rte_addr_gen
  import rte_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] base_i,
  input  seq_state_e    state_i,
  output logic [AW-1:0] addr_o
);

  logic [3:0] ofs;

  always_comb begin
    case (state_i)
      ST_FMT:  ofs = OFS_FMT;
      ST_VER:  ofs = OFS_VER;
      ST_SR:   ofs = OFS_SR;
      ST_PCH:  ofs = OFS_PCH;
      ST_PCL:  ofs = OFS_PCL;
      default: ofs = OFS_SR;
    endcase
  end

  assign addr_o = base_i + AW'(ofs);

endmodule

// File: rtl/rte_ctx_regs.sv
module rte_ctx_regs #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_i,
  input  logic [DW-1:0]   sr_d_i,
  input  logic [2*DW-1:0] pc_d_i,
  input  logic [AW-1:0]   ssp_d_i,
  output logic [DW-1:0]   sr_q_o,
  output logic [2*DW-1:0] pc_q_o,
  output logic [AW-1:0]   ssp_q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q_o  <= '0;
      pc_q_o  <= '0;
      ssp_q_o <= '0;
    end else if (commit_i) begin
      sr_q_o  <= sr_d_i;
      pc_q_o  <= pc_d_i;
      ssp_q_o <= ssp_d_i;
    end
  end

  // R8: context registers hold whenever no commit was requested
  a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(sr_q_o) && $stable(pc_q_o) && $stable(ssp_q_o)));

endmodule

// File: rtl/rte_restore_seq.sv
module rte_restore_seq
  import rte_pkg::*;
#(
  parameter int         AW      = 24,
  parameter int         DW      = 16,
  parameter logic [3:0] VERSION = 4'h1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   ssp_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic [DW-1:0]   rd_data_i,
  input  logic            rd_valid_i,
  output logic [DW-1:0]   sr_o,
  output logic [2*DW-1:0] pc_o,
  output logic [AW-1:0]   ssp_o,
  output logic            done_o,
  output logic            fmt_err_o
);

  localparam int CODE_LSB = DW - 4;

  seq_state_e    state_q, state_d;
  frame_kind_e   kind_q, kind_d, dec_kind;
  logic [AW-1:0] base_q, base_d;
  logic [DW-1:0] sr_buf_q, sr_buf_d;
  logic [DW-1:0] pch_buf_q, pch_buf_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          commit;
  logic [3:0]    field_nib;

  assign field_nib = rd_data_i[DW-1:CODE_LSB];

  rte_frame_decode u_decode (
    .code_i (field_nib),
    .kind_o (dec_kind)
  );

  rte_addr_gen #(.AW(AW)) u_addr (
    .base_i  (base_q),
    .state_i (state_q),
    .addr_o  (rd_addr_o)
  );

  rte_ctx_regs #(.AW(AW), .DW(DW)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .sr_d_i   (sr_buf_q),
    .pc_d_i   ({pch_buf_q, rd_data_i}),
    .ssp_d_i  (base_q + AW'(frame_bytes(kind_q))),
    .sr_q_o   (sr_o),
    .pc_q_o   (pc_o),
    .ssp_q_o  (ssp_o)
  );

  assign rd_req_o  = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign fmt_err_o = err_q;

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    base_d    = base_q;
    sr_buf_d  = sr_buf_q;
    pch_buf_d = pch_buf_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    commit    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          base_d  = ssp_i;
          state_d = ST_FMT;
        end
      end
      ST_FMT: begin
        if (rd_valid_i) begin
          kind_d = dec_kind;
          if (dec_kind == FR_BAD) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (dec_kind == FR_FAULT) begin
            state_d = ST_VER;
          end else begin
            state_d = ST_SR;
          end
        end
      end
      ST_VER: begin
        if (rd_valid_i) begin
          if (field_nib != VERSION) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_SR;
          end
        end
      end
      ST_SR: begin
        if (rd_valid_i) begin
          sr_buf_d = rd_data_i;
          state_d  = ST_PCH;
        end
      end
      ST_PCH: begin
        if (rd_valid_i) begin
          pch_buf_d = rd_data_i;
          state_d   = ST_PCL;
        end
      end
      ST_PCL: begin
        if (rd_valid_i) begin
          commit  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= FR_SHORT;
      base_q    <= '0;
      sr_buf_q  <= '0;
      pch_buf_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      kind_q    <= kind_d;
      base_q    <= base_d;
      sr_buf_q  <= sr_buf_d;
      pch_buf_q <= pch_buf_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6 / R7: a rejection is always reported with done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err_o |-> done_o);

  // R10: address held while a read waits
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R8: outputs move only on a successful finish
  a_r8_change_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ssp_o) || !$stable(sr_o) || !$stable(pc_o)) |-> (done_o && !fmt_err_o));

  // R3 / R4 / R5: stack pointer advances by one of the legal frame sizes
  a_r5_ssp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fmt_err_o) |-> ((ssp_o - base_q) == AW'(8) ||
                                (ssp_o - base_q) == AW'(12) ||
                                (ssp_o - base_q) == AW'(24)));

endmodule

// File: tb/rte_restore_seq_bench.sv
module rte_restore_seq_bench;

  localparam int         AW   = 10;
  localparam int         DW   = 16;
  localparam logic [3:0] VER  = 4'hA;
  localparam int         WORDS = 1 << (AW - 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [AW-1:0]   ssp_i;
  logic            rd_req_o;
  logic [AW-1:0]   rd_addr_o;
  logic [DW-1:0]   rd_data_i;
  logic            rd_valid_i;
  logic [DW-1:0]   sr_o;
  logic [2*DW-1:0] pc_o;
  logic [AW-1:0]   ssp_o;
  logic            done_o;
  logic            fmt_err_o;

  always #2.5 clk = ~clk;

  rte_restore_seq #(.AW(AW), .DW(DW), .VERSION(VER)) u_rte_restore_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ssp_i(ssp_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .rd_valid_i(rd_valid_i), .sr_o(sr_o), .pc_o(pc_o), .ssp_o(ssp_o),
    .done_o(done_o), .fmt_err_o(fmt_err_o)
  );

  logic [DW-1:0] mem [WORDS];
  int            lat;
  int            wait_cnt;
  int            n_reads;
  logic [AW-1:0] first_addr;
  logic [AW-1:0] held_addr;
  int            addr_slips;
  int            n_checks;
  int            n_fail;

  // memory responder, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_valid_i <= 1'b0;
      rd_data_i  <= '0;
      wait_cnt   <= 0;
    end else if (rd_valid_i) begin
      rd_valid_i <= 1'b0;
      wait_cnt   <= 0;
    end else if (rd_req_o) begin
      if (wait_cnt > 0 && rd_addr_o != held_addr) addr_slips <= addr_slips + 1;
      held_addr <= rd_addr_o;
      if (wait_cnt >= lat) begin
        rd_valid_i <= 1'b1;
        rd_data_i  <= mem[rd_addr_o[AW-1:1]];
        if (n_reads == 0) first_addr <= rd_addr_o;
        n_reads <= n_reads + 1;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DW-1:0]   exp_sr;
  logic [2*DW-1:0] exp_pc;
  logic [AW-1:0]   exp_ssp;

  // run one restore; extra_start pulses start again mid-operation
  task automatic run_frame(input logic [AW-1:0] base, input logic [3:0] code,
                           input logic [3:0] ver, input bit extra_start);
    logic [AW-1:0] a;
    logic [DW-1:0] w_sr, w_ph, w_pl;
    bit            good;
    int            exp_reads;
    int            size;
    string         req;
    int            guard;
    for (int i = 0; i < WORDS; i++) mem[i] = DW'(i * 37 + base * 5 + code);
    w_sr = DW'(base * 13 + 16'h1234);
    w_ph = DW'(base * 7 + 16'h8100 + code);
    w_pl = DW'(base * 3 + 16'h0F0F);
    a = base + AW'(0); mem[a[AW-1:1]] = w_sr;
    a = base + AW'(2); mem[a[AW-1:1]] = w_ph;
    a = base + AW'(4); mem[a[AW-1:1]] = w_pl;
    a = base + AW'(6); mem[a[AW-1:1]] = {code, 12'h0A5};
    a = base + AW'(8); mem[a[AW-1:1]] = {ver, 12'h3C3};
    case (code)
      4'h0: begin good = 1; size = 8;  exp_reads = 4; req = "R3"; end
      4'h2: begin good = 1; size = 12; exp_reads = 4; req = "R4"; end
      4'hC: begin
        good = (ver == VER); size = 24;
        exp_reads = good ? 5 : 2; req = good ? "R5" : "R7";
      end
      default: begin good = 0; size = 0; exp_reads = 1; req = "R6"; end
    endcase
    @(negedge clk);
    n_reads = 0;
    ssp_i   = base;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ssp_i   = ~base;
    if (extra_start) begin
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(done_o, "R9", 64'(done_o), 64'd1);
    chk(fmt_err_o == !good, req, 64'(fmt_err_o), 64'(!good));
    if (good) begin
      exp_sr  = w_sr;
      exp_pc  = {w_ph, w_pl};
      exp_ssp = base + AW'(size);
    end
    chk(sr_o == exp_sr, good ? "R8" : req, 64'(sr_o), 64'(exp_sr));
    chk(pc_o == exp_pc, req, 64'(pc_o), 64'(exp_pc));
    chk(ssp_o == exp_ssp, req, 64'(ssp_o), 64'(exp_ssp));
    chk(n_reads == exp_reads, extra_start ? "R11" : req, 64'(n_reads),
        64'(exp_reads));
    chk(first_addr == base + AW'(6), "R2", 64'(first_addr), 64'(base + AW'(6)));
    @(negedge clk);
    chk(!done_o && !rd_req_o, "R9", 64'({done_o, rd_req_o}), 64'd0);
    if (extra_start) begin
      repeat (4) @(negedge clk);
      chk(n_reads == exp_reads && !rd_req_o, "R11", 64'(n_reads), 64'(exp_reads));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0; addr_slips = 0; n_reads = 0;
    lat = 0; first_addr = '0; held_addr = '0;
    rst_n = 1'b0; start_i = 1'b0; ssp_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sr_o == '0 && pc_o == '0 && ssp_o == '0, "R1",
        64'(ssp_o), 64'd0);
    chk(!done_o && !fmt_err_o && !rd_req_o, "R1",
        64'({done_o, fmt_err_o, rd_req_o}), 64'd0);
    rst_n = 1'b1;
    exp_sr = '0; exp_pc = '0; exp_ssp = '0;
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int c = 0; c < 16; c++) begin
        run_frame(AW'((c * 52 + l * 18 + 8) & 'h3FE), 4'(c), VER, 1'b0);
        if (c == 'hC)
          run_frame(AW'((c * 40 + l * 6 + 2) & 'h3FE), 4'(c), VER ^ 4'(l + 1), 1'b0);
      end
      // frames that wrap past the top of the address space
      run_frame(AW'('h3FA), 4'h0, VER, 1'b0);
      run_frame(AW'('h3F6), 4'hC, VER, 1'b0);
      // start during a running operation
      run_frame(AW'('h120), 4'h2, VER, 1'b1);
    end
    chk(addr_slips == 0, "R10", 64'(addr_slips), 64'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule